// File: doc/BRIEF.md
# Step-Mode Random Rule Index Generator

This block hands out one pseudo-random rule index per request, spread nearly evenly over the range 0 to RULES-1. RULES need not be a power of two. It is meant for step-wise stochastic update of a rule network. Every draw is independent of the earlier ones, so a rule may come up again before every other rule has had a turn.

A 10-bit maximal-length shift register supplies the random word. The block reduces that word modulo RULES, so every code becomes a usable index and no draw is thrown away. Using a plain 6-bit word as the index for 37 rules would waste 27 of its 64 codes.

The random word is wider than the index. An elaboration check requires that the leftover bias, (2^RAND_W mod RULES) / 2^RAND_W, stays below a threshold parameter given in parts per thousand.

The reduction is a restoring remainder that handles one dividend bit per clock. A request is accepted only while no reduction is in progress. The result arrives with a one-cycle valid pulse and stays on the index output until the next result replaces it.

Top module: `rand_rule_index`

## Requirements
- R1: The index equals the random word captured at acceptance, taken modulo RULES (37 by default), so it is always below RULES and no draw is lost.
- R2: The random word is a 10-bit Fibonacci shift register with taps at stages 10 and 7. Its next state is {s[8:0], s[9]^s[6]}.
- R3: While reset is held, the register loads seed_i. A zero seed is replaced by 1.
- R4: The first request after reset reduces the seed word itself. Each accepted request then advances the register by exactly one step.
- R5: valid_o is high for exactly one cycle, RAND_W clock edges after the edge that accepted the request.
- R6: A request that arrives while a reduction is running is ignored and does not advance the register. A request held high continuously yields one result every RAND_W+1 cycles.
- R7: After reset, valid_o is 0 and index_o is 0. index_o keeps its value in every cycle in which valid_o is low.
- R8: Draws are independent, so an index can repeat before every index has been produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_i | input | RAND_W | Seed loaded into the shift register during reset |
| req_i | input | 1 | Request for one index |
| index_o | output | $clog2(RULES) | Reduced rule index |
| valid_o | output | 1 | One-cycle pulse marking a new index |

## Verification
The bench checks each result against its own model of the shift register and of the modulo operation. It uses four kinds of seed. Boundary seeds (all ones, an exact multiple of RULES, RULES-1, RULES itself) catch off-by-one faults in the restoring step. A zero seed shows the substitution rule. A long run of isolated requests shows the register stepping and the repeat of an index. A request held high through a reduction tells apart a design that ignores requests while busy from one that re-arms or advances twice; it also fixes the result spacing at RAND_W+1 cycles.

// File: rtl/rri_pkg.sv
package rri_pkg;
   // Tap mask for a maximal-length Fibonacci register, bit i = stage i+1
   function automatic logic [31:0] tap_mask(input int width);
      logic [31:0] m;
      m = '0;
      case (width)
         8:  begin m[7] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
         10: begin m[9] = 1'b1; m[6] = 1'b1; end
         12: begin m[11] = 1'b1; m[10] = 1'b1; m[9] = 1'b1; m[3] = 1'b1; end
         16: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3] = 1'b1; end
         default: m = '0;
      endcase
      return m;
   endfunction

   typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_REDUCE = 1'b1} rri_state_e;
endpackage

// File: rtl/rri_lfsr.sv
module rri_lfsr
   import rri_pkg::*;
#(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] seed_i,
   input  logic         adv_i,
   output logic [W-1:0] word_o
);
   localparam logic [31:0] MASK32 = tap_mask(W);
   localparam logic [W-1:0] MASK  = MASK32[W-1:0];

   if (MASK32 == 32'd0) begin : g_bad_width
      $error("rri_lfsr: no tap set for width %0d", W);
   end

   logic [W-1:0] state_q;
   logic         fb;

   assign fb = ^(state_q & MASK);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= (seed_i == '0) ? W'(1) : seed_i;
      end else if (adv_i) begin
         state_q <= {state_q[W-2:0], fb};
      end
   end

   assign word_o = state_q;

   // R3
   lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      state_q != '0);
   // R6
   lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !adv_i |=> $stable(state_q));
endmodule

// File: rtl/rri_mod_reduce.sv
module rri_mod_reduce
   import rri_pkg::*;
#(
   parameter int DIV_W   = 10,
   parameter int MODULUS = 37,
   localparam int RES_W  = $clog2(MODULUS),
   localparam int CNT_W  = $clog2(DIV_W + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic [DIV_W-1:0] dividend_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [RES_W-1:0] result_o
);
   localparam logic [RES_W+1:0] MOD_EXT  = (RES_W + 2)'(MODULUS);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DIV_W - 1);

   rri_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DIV_W-1:0] shreg_q;
   logic [RES_W-1:0] rem_q;
   logic [RES_W-1:0] res_q;
   logic             done_q;

   logic [RES_W:0]   shifted;
   logic [RES_W+1:0] trial;
   logic [RES_W-1:0] rem_next;

   always_comb begin
      shifted  = {rem_q, shreg_q[DIV_W-1]};
      trial    = {1'b0, shifted} - MOD_EXT;
      rem_next = trial[RES_W+1] ? shifted[RES_W-1:0] : trial[RES_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         shreg_q <= '0;
         rem_q   <= '0;
         res_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  shreg_q <= dividend_i;
                  rem_q   <= '0;
                  cnt_q   <= '0;
                  st_q    <= ST_REDUCE;
               end
            end
            default: begin
               rem_q   <= rem_next;
               shreg_q <= {shreg_q[DIV_W-2:0], 1'b0};
               cnt_q   <= cnt_q + 1'b1;
               if (cnt_q == LAST_CNT) begin
                  res_q  <= rem_next;
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign busy_o   = (st_q == ST_REDUCE);
   assign done_o   = done_q;
   assign result_o = res_q;

   // R1
   rem_range_chk: assert property (@(posedge clk) disable iff (rst)
      busy_o |-> (rem_q < MOD_EXT[RES_W-1:0] || MODULUS == (1 << RES_W)));
   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);
endmodule

// File: rtl/rand_rule_index.sv
module rand_rule_index
   import rri_pkg::*;
#(
   parameter int RULES          = 37,
   parameter int RAND_W         = 10,
   parameter int BIAS_PERMILLE  = 30,
   localparam int IDX_W         = $clog2(RULES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [RAND_W-1:0] seed_i,
   input  logic              req_i,
   output logic [IDX_W-1:0]  index_o,
   output logic              valid_o
);
   localparam longint SPAN    = longint'(1) << RAND_W;
   localparam longint LEFTOVER = SPAN % longint'(RULES);

   if (RULES < 2) begin : g_bad_rules
      $error("rand_rule_index: RULES must be at least 2");
   end
   if (RAND_W <= IDX_W) begin : g_bad_width
      $error("rand_rule_index: RAND_W must exceed the index width");
   end
   if (LEFTOVER * 1000 >= longint'(BIAS_PERMILLE) * SPAN) begin : g_bad_bias
      $error("rand_rule_index: modulo bias above threshold");
   end

   logic              busy;
   logic              accept;
   logic [RAND_W-1:0] word;

   assign accept = req_i && !busy;

   rri_lfsr #(.W(RAND_W)) u_lfsr (
      .clk    (clk),
      .rst    (rst),
      .seed_i (seed_i),
      .adv_i  (accept),
      .word_o (word)
   );

   rri_mod_reduce #(.DIV_W(RAND_W), .MODULUS(RULES)) u_reduce (
      .clk        (clk),
      .rst        (rst),
      .start_i    (accept),
      .dividend_i (word),
      .busy_o     (busy),
      .done_o     (valid_o),
      .result_o   (index_o)
   );

   // R1
   index_range_chk: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> (32'(index_o) < RULES));
   // R7
   index_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !valid_o |-> $stable(index_o));
   // R6
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
      accept |=> busy);
endmodule

// File: tb/tb_rand_rule_index.sv
module tb_rand_rule_index;
   localparam int RULES  = 37;
   localparam int RAND_W = 10;
   localparam int IDX_W  = $clog2(RULES);

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [RAND_W-1:0] seed_i = '0;
   logic              req_i = 1'b0;
   logic [IDX_W-1:0]  index_o;
   logic              valid_o;

   int checks = 0;
   int errors = 0;
   logic [RAND_W-1:0] model;

   always #5 clk = ~clk;

   rand_rule_index #(.RULES(RULES), .RAND_W(RAND_W)) dut (
      .clk(clk), .rst(rst), .seed_i(seed_i), .req_i(req_i),
      .index_o(index_o), .valid_o(valid_o)
   );

   function automatic logic [RAND_W-1:0] step(input logic [RAND_W-1:0] s);
      return {s[8:0], s[9] ^ s[6]};
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [RAND_W-1:0] s);
      @(negedge clk);
      rst = 1'b1; seed_i = s; req_i = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model = (s == '0) ? RAND_W'(1) : s;
   endtask

   // one isolated request; returns index, checks latency and pulse width
   task automatic one_req(output int idx, input string tag);
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      for (int i = 1; i <= RAND_W; i++) begin
         @(negedge clk);
         if (i < RAND_W && valid_o) chk(0, {tag, " R5 early valid"}, i, RAND_W);
      end
      chk(valid_o == 1'b1, {tag, " R5 valid at latency"}, valid_o, 1);
      idx = index_o;
      @(negedge clk);
      chk(valid_o == 1'b0, {tag, " R5 single-cycle pulse"}, valid_o, 0);
   endtask

   task automatic t_reset();
      do_reset(10'h155);
      chk(valid_o == 1'b0, "R7 reset valid", valid_o, 0);
      chk(index_o == '0, "R7 reset index", index_o, 0);
   endtask

   task automatic t_seed(input logic [RAND_W-1:0] s, input string tag);
      int idx;
      do_reset(s);
      one_req(idx, tag);
      chk(idx == int'(model) % RULES, {tag, " R1 R3 R4 first index"}, idx, int'(model) % RULES);
      model = step(model);
      one_req(idx, tag);
      chk(idx == int'(model) % RULES, {tag, " R2 R4 second index"}, idx, int'(model) % RULES);
   endtask

   task automatic t_stream();
      int idx, exp;
      bit seen [RULES];
      int distinct;
      bit repeat_early;
      for (int k = 0; k < RULES; k++) seen[k] = 1'b0;
      distinct = 0; repeat_early = 1'b0;
      do_reset(10'h2A5);
      for (int n = 0; n < 60; n++) begin
         one_req(idx, "stream");
         exp = int'(model) % RULES;
         chk(idx == exp, "R1 R2 stream index", idx, exp);
         chk(idx < RULES, "R1 no miss", idx, RULES - 1);
         if (idx < RULES) begin
            if (seen[idx] && distinct < RULES) repeat_early = 1'b1;
            if (!seen[idx]) distinct++;
            seen[idx] = 1'b1;
         end
         model = step(model);
         repeat (3) @(negedge clk);
         chk(index_o == idx[IDX_W-1:0], "R7 index held", index_o, idx);
      end
      chk(repeat_early, "R8 repeat before full coverage", repeat_early, 1);
   endtask

   task automatic t_held();
      int nvalid, exp;
      do_reset(10'h3C1);
      nvalid = 0;
      req_i = 1'b1;
      for (int cyc = 1; cyc <= 100; cyc++) begin
         @(negedge clk);
         if (cyc % (RAND_W + 1) == 0) begin
            exp = int'(model) % RULES;
            chk(valid_o == 1'b1, "R6 held-request spacing", valid_o, 1);
            chk(index_o == exp, "R6 held-request index", index_o, exp);
            model = step(model);
            nvalid++;
         end else if (valid_o) begin
            chk(0, "R6 unexpected valid", cyc, (cyc / (RAND_W + 1) + 1) * (RAND_W + 1));
         end
      end
      req_i = 1'b0;
      chk(nvalid == 9, "R6 result count", nvalid, 9);
      repeat (RAND_W + 3) @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_seed(10'h3FF, "ones");
      t_seed(10'd999, "multiple");
      t_seed(10'd36,  "rules-1");
      t_seed(10'd37,  "rules");
      t_seed(10'd0,   "zero-seed");
      t_stream();
      t_held();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule